// File: doc/BRIEF.md
# Transmit Packet Buffer with Collision Rewind

This block is the word buffer that sits between a port's host-side loader and its serial transmitter. The loader writes 32-bit double words. The last double word of each packet carries an end-of-frame tag. The transmitter pulls words one at a time and reads the tag with each word. When the tag is set, the transmitter decides whether to append a CRC or, in no-CRC mode, to end the frame at once.

Reading a word does not release its storage. The buffer keeps a packet-start pointer, so every word of the attempt that is in progress stays stored. When a collision is reported, the read pointer returns to the packet start and the same words are delivered again for the retransmission. A successful attempt releases everything read so far. A fatal retry condition empties the whole buffer.

If the transmitter asks for a word while it is partway through a packet and no unread word has been written yet, the buffer raises an underflow pulse one cycle later.

Top module: `tx_rewind_fifo`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1, and `full`, `rd_avail` and `underflow` are 0.
- R2: Words are delivered in the order written. While `rd_avail` is 1, `rd_data` and `rd_eof` show the oldest unread word together with the tag written with it, and a cycle with `rd_req` high advances to the next word.
- R3: `full` is 1 when DEPTH words are held, counted from the packet start. A write while `full` is dropped, and the dropped word is never delivered.
- R4: Reading does not free storage. Once a word has been written, `empty` stays 0 until a successful completion or a flush, even after every word has been read.
- R5: A `tx_collide` cycle moves the read position back to the first word held since the packet start. The next cycle shows that word again with `rd_avail` 1.
- R6: A `tx_done` cycle releases every word read so far. Unread words stay in place, and `empty` is 1 only when none remain.
- R7: A `tx_flush` cycle discards every stored word. A write in the same cycle is also dropped, so the next cycle shows `empty` 1 and `rd_avail` 0.
- R8: `underflow` pulses high for one cycle, in the cycle after a `rd_req` that finds no unread word while a packet is in progress. A packet is in progress after a word with tag 0 has been read, and stops being in progress once a tagged word is read or a collide, done or flush cycle occurs. A request made while no packet is in progress raises nothing.
- R9: When more than one of `tx_flush`, `tx_collide` and `tx_done` is high, flush wins over collide, and collide wins over done. In any cycle where one of them is high, `rd_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write a word |
| wr_data | input | DATA_W | Word to write |
| wr_eof | input | 1 | End-of-frame tag for the word being written |
| full | output | 1 | DEPTH words held |
| empty | output | 1 | No words held |
| rd_req | input | 1 | Transmitter takes the current word |
| rd_data | output | DATA_W | Oldest unread word |
| rd_eof | output | 1 | Tag of the oldest unread word |
| rd_avail | output | 1 | An unread word is present |
| underflow | output | 1 | One-cycle pulse: a word was requested mid-packet and none was present |
| tx_collide | input | 1 | Collision; rewind to packet start |
| tx_done | input | 1 | Attempt succeeded; release words read |
| tx_flush | input | 1 | Fatal retry condition; discard everything |

## Verification
The bench builds the buffer with DEPTH 8 and keeps DATA_W at 32. The small depth means random traffic often fills the buffer, so dropped writes while full and rewinds across a completely full buffer occur many times. The pointers also wrap repeatedly during the run, which exercises the extra wrap bit used to tell full from empty. With a 32-bit word, a dropped or replayed word cannot be mistaken for a legitimate one.

// File: rtl/tx_fifo_pkg.sv
// Shared constants for the transmit packet buffer.
// Assumes: a word is one double word; the tag is carried beside it.
package tx_fifo_pkg;
    localparam int unsigned TXF_DATA_W = 32;
    localparam int unsigned TXF_DEPTH  = 16;
endpackage

// File: rtl/tx_fifo_store.sv
// Storage array for the transmit buffer: one write port, one combinational
// read port. Each entry holds the data word plus its end-of-frame tag.
// Assumes: the controller never writes while full, so no guard is needed here.
module tx_fifo_store #(
    parameter int unsigned DATA_W = tx_fifo_pkg::TXF_DATA_W,
    parameter int unsigned DEPTH  = tx_fifo_pkg::TXF_DEPTH,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned ENT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              weof,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              reof
);
    logic [ENT_W-1:0] mem [DEPTH];

    // Capture an accepted word with its tag in the top bit.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {weof, wdata};
        end
    end

    // Present the entry at the read address.
    always_comb begin
        rdata = mem[raddr][DATA_W-1:0];
        reof  = mem[raddr][ENT_W-1];
    end
endmodule

// File: rtl/tx_fifo_ctrl.sv
// Pointer control for the transmit buffer. It keeps three pointers, each one
// bit wider than the address: write, read, and packet start. Storage is
// counted from the packet start, so words that have been read stay held until
// a successful completion. Flush outranks collide, and collide outranks done.
// Any of the three blocks a read in the same cycle.
// Assumes: DEPTH is a power of two.
module tx_fifo_ctrl #(
    parameter int unsigned DEPTH = tx_fifo_pkg::TXF_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_req,
    input  logic          tx_collide,
    input  logic          tx_done,
    input  logic          tx_flush,
    input  logic          head_eof,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full,
    output logic          empty,
    output logic          rd_avail,
    output logic          underflow
);
    logic [PW-1:0] wr_ptr, rd_ptr, start_ptr;
    logic [PW-1:0] held, unread;
    logic          in_pkt;
    logic          ctl_any;
    logic          rd_fire;

    // Derive occupancy flags and the accepted read and write strobes.
    always_comb begin
        held     = wr_ptr - start_ptr;
        unread   = wr_ptr - rd_ptr;
        full     = (held == PW'(DEPTH));
        empty    = (held == '0);
        rd_avail = (unread != '0);
        ctl_any  = tx_flush | tx_collide | tx_done;
        wr_fire  = wr_en & ~full & ~tx_flush;
        rd_fire  = rd_req & rd_avail & ~ctl_any;
        waddr    = wr_ptr[AW-1:0];
        raddr    = rd_ptr[AW-1:0];
    end

    // Advance the write pointer on each accepted word; flush resets it.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_flush) begin
            wr_ptr <= '0;
        end else if (wr_fire) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Move the read and start pointers as the control inputs and reads direct.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_flush) begin
            rd_ptr    <= '0;
            start_ptr <= '0;
        end else if (tx_collide) begin
            rd_ptr    <= start_ptr;
        end else if (tx_done) begin
            start_ptr <= rd_ptr;
        end else if (rd_fire) begin
            rd_ptr    <= rd_ptr + 1'b1;
        end
    end

    // Track whether a packet is part-way through transmission.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_any) begin
            in_pkt <= 1'b0;
        end else if (rd_fire) begin
            in_pkt <= ~head_eof;
        end
    end

    // Flag a request made mid-packet that found no unread word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow <= 1'b0;
        end else begin
            underflow <= rd_req & ~rd_avail & in_pkt & ~ctl_any;
        end
    end
endmodule

// File: rtl/tx_rewind_fifo.sv
// Transmit packet buffer with collision rewind. The loader writes tagged
// double words. The transmitter reads them, and a collision replays the
// packet from its start. Success releases the words read; flush empties the
// buffer.
// Assumes: one word per transmitter request; the control inputs are
// single-cycle strobes.
module tx_rewind_fifo #(
    parameter int unsigned DATA_W = tx_fifo_pkg::TXF_DATA_W,
    parameter int unsigned DEPTH  = tx_fifo_pkg::TXF_DEPTH,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eof,
    output logic              full,
    output logic              empty,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eof,
    output logic              rd_avail,
    output logic              underflow,
    input  logic              tx_collide,
    input  logic              tx_done,
    input  logic              tx_flush
);
    logic          wr_fire;
    logic [AW-1:0] waddr, raddr;

    tx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req),
        .tx_collide(tx_collide), .tx_done(tx_done), .tx_flush(tx_flush),
        .head_eof(rd_eof), .wr_fire(wr_fire), .waddr(waddr), .raddr(raddr),
        .full(full), .empty(empty), .rd_avail(rd_avail), .underflow(underflow)
    );

    tx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .weof(wr_eof), .raddr(raddr), .rdata(rd_data), .reof(rd_eof)
    );
endmodule

// File: rtl/tx_rewind_fifo_chk.sv
// Port-level property checker for the transmit packet buffer.
module tx_rewind_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_req,
    input logic tx_collide,
    input logic tx_done,
    input logic tx_flush,
    input logic full,
    input logic empty,
    input logic rd_avail,
    input logic underflow
);
    // R1: the cycle after reset shows an empty buffer
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (empty && !full && !rd_avail && !underflow));

    // R3: full and empty never hold together
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3: a write while full leaves the buffer full
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !tx_done && !tx_flush) |=> full);

    // R4: a plain read never empties a held buffer
    a_r4_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !tx_done && !tx_flush) |=> !empty);

    // R5: rewind with words held makes one available
    a_r5_rewind_avail: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_collide && !tx_flush && !empty) |=> rd_avail);

    // R7: flush empties the buffer
    a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (empty && !rd_avail));

    // R8: underflow only follows a request that found no word
    a_r8_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($past(rd_req) && !$past(rd_avail)));

    // R9: no underflow follows a control cycle
    a_r9_ctl_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush || tx_collide || tx_done) |=> !underflow);
endmodule

bind tx_rewind_fifo tx_rewind_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req),
    .tx_collide(tx_collide), .tx_done(tx_done), .tx_flush(tx_flush),
    .full(full), .empty(empty), .rd_avail(rd_avail), .underflow(underflow)
);

// File: tb/tb_tx_rewind_fifo.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a queue model of the requirements.
module tb_tx_rewind_fifo;
    localparam int unsigned DW = 32;
    localparam int unsigned DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_eof = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          tx_collide = 1'b0, tx_done = 1'b0, tx_flush = 1'b0;
    logic          full, empty, rd_avail, underflow, rd_eof;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [DW:0] q[$];
    int  rd_idx = 0;
    bit  act = 0;
    bit  exp_under = 0;

    tx_rewind_fifo #(.DATA_W(DW), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eof(wr_eof), .full(full), .empty(empty), .rd_req(rd_req),
        .rd_data(rd_data), .rd_eof(rd_eof), .rd_avail(rd_avail),
        .underflow(underflow), .tx_collide(tx_collide), .tx_done(tx_done),
        .tx_flush(tx_flush)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, a, e);
        end
    endtask

    // Model step from the pre-edge state and inputs.
    function automatic void model_step();
        int  occ = q.size();
        bit  avail = rd_idx < occ;
        bit  ctl = tx_flush | tx_collide | tx_done;
        bit  fl = (occ == DP);
        exp_under = rd_req && !avail && act && !ctl;
        if (tx_flush) begin
            q.delete(); rd_idx = 0; act = 0;
        end else if (tx_collide) begin
            rd_idx = 0; act = 0;
        end else if (tx_done) begin
            for (int i = 0; i < rd_idx; i++) void'(q.pop_front());
            rd_idx = 0; act = 0;
        end else if (rd_req && avail) begin
            act = !q[rd_idx][DW];
            rd_idx++;
        end
        if (wr_en && !fl && !tx_flush) q.push_back({wr_eof, wr_data});
    endfunction

    task automatic compare();
        bit av = rd_idx < q.size();
        chk(empty == (q.size() == 0), "R6 empty", empty, q.size() == 0);
        chk(full == (q.size() == DP), "R3 full", full, q.size() == DP);
        chk(rd_avail == av, "R2 rd_avail", rd_avail, av);
        chk(underflow == exp_under, "R8 underflow", underflow, exp_under);
        if (av) chk({rd_eof, rd_data} == q[rd_idx], "R2 head word", {rd_eof, rd_data}, q[rd_idx]);
    endtask

    task automatic cyc(input bit w, input logic [DW-1:0] d, input bit e, input bit r,
                       input bit c, input bit dn, input bit f);
        @(negedge clk);
        wr_en = w; wr_data = d; wr_eof = e; rd_req = r;
        tx_collide = c; tx_done = dn; tx_flush = f;
        @(posedge clk);
        model_step();
        #2;
        compare();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        chk(empty && !full && !rd_avail && !underflow, "R1 reset state",
            {empty, full, rd_avail, underflow}, 4'b1000);
        @(negedge clk); rst_n = 1'b1;

        // R3: fill past full; the extra word must never appear
        for (int i = 0; i < DP; i++) cyc(1, 32'hA000 + i, i == DP - 1, 0, 0, 0, 0);
        cyc(1, 32'hDEAD, 0, 0, 0, 0, 0);
        chk(full, "R3 full after depth writes", full, 1);
        // R4: read everything; storage stays held
        for (int i = 0; i < DP; i++) cyc(0, 0, 0, 1, 0, 0, 0);
        chk(!empty && full && !rd_avail, "R4 read keeps storage", {empty, full, rd_avail}, 3'b010);
        // R5: rewind returns the first word
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk(rd_avail && rd_data == 32'hA000, "R5 rewind head", rd_data, 32'hA000);
        // R6: read three, done releases them
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk(!full && rd_data == 32'hA003, "R6 done frees read words", rd_data, 32'hA003);
        // R9: flush, collide and done together with a read: flush wins
        cyc(1, 32'hBEEF, 0, 1, 1, 1, 1);
        chk(empty && !rd_avail, "R7 R9 flush wins, write dropped", {empty, rd_avail}, 2'b10);
        // R8: underflow mid-packet
        cyc(1, 32'hC000, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(underflow, "R8 mid-packet underflow", underflow, 1);
        // R8: no underflow after the tagged word
        cyc(1, 32'hC001, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(!underflow, "R8 idle request silent", underflow, 0);
        // R9: collide with done keeps words (collide wins)
        cyc(0, 0, 0, 0, 1, 1, 0);
        chk(rd_avail && rd_data == 32'hC000, "R9 collide over done", rd_data, 32'hC000);
        cyc(0, 0, 0, 0, 0, 0, 1);

        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            int unsigned p = $urandom_range(0, 99);
            cyc($urandom_range(0, 99) < 55, $urandom(), $urandom_range(0, 5) == 0,
                $urandom_range(0, 99) < 50, p < 3, p >= 3 && p < 7, p == 99);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule